// File: doc/BRIEF.md
# EPROM Operating Mode Emulator

This block stands in for a byte-wide ultraviolet-erasable / one-time-programmable EPROM inside a synchronous design. It samples the chip-enable, the combined output-enable/programming-supply pin (carried as a two-bit level code), an identification-voltage flag for address bit 9, the address and the data bus on every clock. From these it works out which of six operating modes is in force: read, output disable, program, program inhibit, standby and signature. It then drives a registered data bus with an output-enable qualifier, so a surrounding model can turn that into a tri-state pin.

Programming behaves like a floating-gate cell: a write can only clear bits, so the stored byte becomes the AND of its old value and the applied data. A synchronous erase pulse, and reset, bring every byte back to all ones. This is done by a sweep through the array, one word per clock, so the storage stays an inferable dual-port block RAM. A margin-mode flag register is also kept. It is set or cleared by a program-style pulse applied with the identification voltage present.

Top module: `eprom_emu`

## Requirements
- R1: After reset, `dout_oe_o`, `sig_err_o` and `margin_o` are 0 and every array byte reads 8'hFF.
- R2: Read mode (`ce_n_i`=0, `oe_vpp_lvl_i`=2'b00, `id_hv_i`=0) drives the stored byte with `dout_oe_o`=1 two clocks after the inputs are sampled; address bits above ARR_AW are ignored, so addresses alias.
- R3: With `ce_n_i`=0 and the level code 2'b01 (logic high), the outputs are disabled (`dout_oe_o`=0).
- R4: With `ce_n_i`=1 the outputs are disabled for every level code.
- R5: With the level code 2'b10 (programming supply), a low pulse on `ce_n_i` programs on its rising edge, using the address and data present on the last clock that chip enable was low. The new byte is old AND data, so bits only go from 1 to 0.
- R6: With the level code 2'b10 and `ce_n_i`=1 nothing is written and the outputs stay disabled. If the level leaves 2'b10 while chip enable is still low, the later rise of chip enable commits nothing.
- R7: Signature mode (`ce_n_i`=0, level 2'b00, `id_hv_i`=1, every address bit other than bit 0 and bit 9 zero) returns 8'h20 when address bit 0 is 0 and 8'h3D when it is 1, with `sig_err_o`=0.
- R8: A signature request in which any address bit other than bits 0 and 9 is 1 returns the array byte and raises `sig_err_o` in the same cycle as that data.
- R9: A one-cycle `erase_i` pulse makes every byte read 8'hFF. Reads sampled after the pulse already return 8'hFF. Program commits during the following 2^ARR_AW clocks of the sweep are discarded.
- R10: A program-style pulse with `id_hv_i`=1 leaves the array unchanged. It sets `margin_o` when address bit 10 was 1 and clears it when that bit was 0.
- R11: The level code 2'b11 is treated as logic high: it disables the outputs and never programs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts an erase sweep |
| addr_i | input | 16 | Byte address |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_vpp_lvl_i | input | 2 | Output-enable/supply level: 00 low, 01 high, 10 programming supply, 11 treated as high |
| id_hv_i | input | 1 | Identification high voltage present on address bit 9 |
| din_i | input | 8 | Data to program |
| erase_i | input | 1 | Synchronous erase-all pulse |
| dout_o | output | 8 | Registered output data (0 while disabled) |
| dout_oe_o | output | 1 | Output drive enable |
| sig_err_o | output | 1 | Signature requested with stray address bits set |
| margin_o | output | 1 | Margin-mode flag |

## Verification
Output data, its enable and the signature error all appear two rising edges after the inputs are sampled: one edge for the array read and mode register, one for the output register. The bench therefore changes inputs on a falling edge, lets two rising edges pass and samples on the next falling edge. A program commits on the first rising edge that sees chip enable high and writes on the edge after that. The bench reads back only after both edges, and the margin flag is checked after the same two edges. Erase checks wait a full sweep of the array before confirming that a program applied during the sweep was lost.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_READ,
    M_OUT_DIS,
    M_PROGRAM,
    M_INHIBIT,
    M_SIGNATURE
  } mode_e;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_HIGH = 2'b01;
  localparam logic [1:0] LVL_VPP  = 2'b10;
  localparam logic [1:0] LVL_RSVD = 2'b11;

  // Six-row mode table; supply level dominates, then chip enable.
  function automatic mode_e decode_mode(input logic ce_n, input logic [1:0] lvl,
                                        input logic id_hv);
    mode_e m;
    if (lvl == LVL_VPP)      m = ce_n ? M_INHIBIT : M_PROGRAM;
    else if (ce_n)           m = M_STANDBY;
    else if (lvl != LVL_LOW) m = M_OUT_DIS;
    else if (id_hv)          m = M_SIGNATURE;
    else                     m = M_READ;
    return m;
  endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              ce_n_i,
  input  logic [1:0]        lvl_i,
  input  logic              id_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mode_e             mode_o,
  output logic              sig_clean_o
);

  // Bits that may be set during a signature read: bit 0 selects the byte,
  // bit 9 carries the identification voltage.
  logic [ADDR_W-1:0] stray;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_stray
    if (i == 0 || i == 9) begin : g_free
      assign stray[i] = 1'b0;
    end else begin : g_chk
      assign stray[i] = addr_i[i];
    end
  end

  assign sig_clean_o = ~|stray;
  assign mode_o      = decode_mode(ce_n_i, lvl_i, id_hv_i);

endmodule

// File: rtl/eprom_dp_ram.sv
module eprom_dp_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic [AW-1:0] b_addr_i,
  input  logic          b_we_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    a_rdata_o <= mem[a_addr_i];
  end

  always_ff @(posedge clk) begin
    if (b_we_i) mem[b_addr_i] <= b_wdata_i;
    b_rdata_o <= mem[b_addr_i];
  end

endmodule

// File: rtl/eprom_prog_ctl.sv
module eprom_prog_ctl
  import eprom_pkg::*;
#(
  parameter int ARR_AW = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode_i,
  input  logic              ce_n_i,
  input  logic              id_hv_i,
  input  logic              a10_i,
  input  logic [ARR_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              erase_i,
  output logic [ARR_AW-1:0] b_addr_o,
  output logic              b_we_o,
  output logic [DATA_W-1:0] b_wdata_o,
  input  logic [DATA_W-1:0] b_rdata_i,
  output logic              sweep_o,
  output logic              margin_o
);

  localparam int              DEPTH = 1 << ARR_AW;
  localparam logic [ARR_AW-1:0] LAST = ARR_AW'(DEPTH - 1);

  logic              arm_q;
  logic              rd_pend_q;
  logic              sweep_q;
  logic [ARR_AW-1:0] ptr_q;
  logic              margin_q;
  logic [ARR_AW-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_data_q;
  logic              lat_hv_q;
  logic              lat_a10_q;
  logic              commit;

  // Chip enable has just risen out of a program cycle.
  assign commit = arm_q & ce_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q      <= 1'b0;
      rd_pend_q  <= 1'b0;
      sweep_q    <= 1'b1;
      ptr_q      <= '0;
      margin_q   <= 1'b0;
      lat_addr_q <= '0;
      lat_data_q <= '0;
      lat_hv_q   <= 1'b0;
      lat_a10_q  <= 1'b0;
    end else begin
      arm_q <= (mode_i == M_PROGRAM);
      if (mode_i == M_PROGRAM) begin
        lat_addr_q <= addr_i;
        lat_data_q <= din_i;
        lat_hv_q   <= id_hv_i;
        lat_a10_q  <= a10_i;
      end
      if (erase_i) begin
        sweep_q <= 1'b1;
        ptr_q   <= '0;
      end else if (sweep_q) begin
        ptr_q <= ptr_q + 1'b1;
        if (ptr_q == LAST) sweep_q <= 1'b0;
      end
      rd_pend_q <= commit & ~lat_hv_q & ~sweep_q & ~erase_i;
      if (commit && lat_hv_q) margin_q <= lat_a10_q;
    end
  end

  // Port B: erase sweep has priority, else read-modify-write of the latched byte.
  always_comb begin
    if (sweep_q) begin
      b_addr_o  = ptr_q;
      b_we_o    = 1'b1;
      b_wdata_o = '1;
    end else if (rd_pend_q) begin
      b_addr_o  = lat_addr_q;
      b_we_o    = 1'b1;
      b_wdata_o = b_rdata_i & lat_data_q;
    end else begin
      b_addr_o  = lat_addr_q;
      b_we_o    = 1'b0;
      b_wdata_o = '0;
    end
  end

  assign sweep_o  = sweep_q;
  assign margin_o = margin_q;

  // R9: a pending program never coexists with the erase sweep.
  p_sweep_excl_r9: assert property (@(posedge clk) disable iff (rst)
    sweep_q |-> !rd_pend_q);

  // R5: a single chip-enable rise yields exactly one write.
  p_commit_once_r5: assert property (@(posedge clk) disable iff (rst)
    rd_pend_q |=> !rd_pend_q);

endmodule

// File: rtl/eprom_out_stage.sv
module eprom_out_stage
  import eprom_pkg::*;
#(
  parameter int         DATA_W = 8,
  parameter logic [7:0] MFR_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'h3D
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode_i,
  input  logic              sig_clean_i,
  input  logic              a0_i,
  input  logic              blank_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o,
  output logic              sig_err_o
);

  mode_e             mode_q;
  logic              clean_q;
  logic              a0_q;
  logic              blank_q;
  logic [DATA_W-1:0] arr_byte;

  // Stage 1: align control with the array read latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_STANDBY;
      clean_q <= 1'b1;
      a0_q    <= 1'b0;
      blank_q <= 1'b1;
    end else begin
      mode_q  <= mode_i;
      clean_q <= sig_clean_i;
      a0_q    <= a0_i;
      blank_q <= blank_i;
    end
  end

  assign arr_byte = blank_q ? '1 : arr_rdata_i;

  // Stage 2: registered output.
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o    <= '0;
      dout_oe_o <= 1'b0;
      sig_err_o <= 1'b0;
    end else begin
      dout_o    <= '0;
      dout_oe_o <= 1'b0;
      sig_err_o <= 1'b0;
      case (mode_q)
        M_READ: begin
          dout_o    <= arr_byte;
          dout_oe_o <= 1'b1;
        end
        M_SIGNATURE: begin
          dout_oe_o <= 1'b1;
          if (clean_q) dout_o <= DATA_W'(a0_q ? DEV_ID : MFR_ID);
          else begin
            dout_o    <= arr_byte;
            sig_err_o <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
  import eprom_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter int         ARR_AW = 11,
  parameter int         DATA_W = 8,
  parameter logic [7:0] MFR_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'h3D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic [1:0]        oe_vpp_lvl_i,
  input  logic              id_hv_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              erase_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o,
  output logic              sig_err_o,
  output logic              margin_o
);

  mode_e             mode;
  logic              sig_clean;
  logic [DATA_W-1:0] a_rdata;
  logic [ARR_AW-1:0] b_addr;
  logic              b_we;
  logic [DATA_W-1:0] b_wdata;
  logic [DATA_W-1:0] b_rdata;
  logic              sweep;

  eprom_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
    .ce_n_i     (ce_n_i),
    .lvl_i      (oe_vpp_lvl_i),
    .id_hv_i    (id_hv_i),
    .addr_i     (addr_i),
    .mode_o     (mode),
    .sig_clean_o(sig_clean)
  );

  eprom_dp_ram #(.AW(ARR_AW), .DW(DATA_W)) u_ram (
    .clk      (clk),
    .a_addr_i (addr_i[ARR_AW-1:0]),
    .a_rdata_o(a_rdata),
    .b_addr_i (b_addr),
    .b_we_i   (b_we),
    .b_wdata_i(b_wdata),
    .b_rdata_o(b_rdata)
  );

  eprom_prog_ctl #(.ARR_AW(ARR_AW), .DATA_W(DATA_W)) u_prog (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode),
    .ce_n_i   (ce_n_i),
    .id_hv_i  (id_hv_i),
    .a10_i    (addr_i[10]),
    .addr_i   (addr_i[ARR_AW-1:0]),
    .din_i    (din_i),
    .erase_i  (erase_i),
    .b_addr_o (b_addr),
    .b_we_o   (b_we),
    .b_wdata_o(b_wdata),
    .b_rdata_i(b_rdata),
    .sweep_o  (sweep),
    .margin_o (margin_o)
  );

  eprom_out_stage #(.DATA_W(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_out (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .sig_clean_i(sig_clean),
    .a0_i       (addr_i[0]),
    .blank_i    (sweep),
    .arr_rdata_i(a_rdata),
    .dout_o     (dout_o),
    .dout_oe_o  (dout_oe_o),
    .sig_err_o  (sig_err_o)
  );

  // Cycles since reset, so two-deep history checks never see reset-era values.
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_read_drives_r2: assert property (@(posedge clk) disable iff (rst || warm_q < 2'd2)
    $past(!ce_n_i && oe_vpp_lvl_i == LVL_LOW && !id_hv_i, 2) |-> dout_oe_o);

  p_outdis_hiz_r3: assert property (@(posedge clk) disable iff (rst || warm_q < 2'd2)
    $past(!ce_n_i && (oe_vpp_lvl_i == LVL_HIGH || oe_vpp_lvl_i == LVL_RSVD), 2)
      |-> !dout_oe_o);

  p_standby_hiz_r4: assert property (@(posedge clk) disable iff (rst || warm_q < 2'd2)
    $past(ce_n_i, 2) |-> (!dout_oe_o && !sig_err_o));

  p_sig_id_r7: assert property (@(posedge clk) disable iff (rst || warm_q < 2'd2)
    $past(!ce_n_i && oe_vpp_lvl_i == LVL_LOW && id_hv_i && sig_clean, 2)
      |-> (dout_o == DATA_W'($past(addr_i[0], 2) ? DEV_ID : MFR_ID)));

  p_err_with_data_r8: assert property (@(posedge clk) disable iff (rst)
    sig_err_o |-> dout_oe_o);

  p_margin_vpp_r10: assert property (@(posedge clk) disable iff (rst || warm_q < 2'd2)
    !$stable(margin_o) |-> $past(oe_vpp_lvl_i == LVL_VPP && id_hv_i, 2));

endmodule

// File: tb/eprom_emu_tb.sv
module eprom_emu_tb_top;

  localparam int ARR_AW = 8;
  localparam int DEPTH  = 1 << ARR_AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        ce_n = 1'b1;
  logic [1:0]  lvl = 2'b00;
  logic        id_hv = 1'b0;
  logic [7:0]  din = '0;
  logic        erase = 1'b0;
  logic [7:0]  dout;
  logic        dout_oe;
  logic        sig_err;
  logic        margin;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  eprom_emu #(.ARR_AW(ARR_AW)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (addr),
    .ce_n_i      (ce_n),
    .oe_vpp_lvl_i(lvl),
    .id_hv_i     (id_hv),
    .din_i       (din),
    .erase_i     (erase),
    .dout_o      (dout),
    .dout_oe_o   (dout_oe),
    .sig_err_o   (sig_err),
    .margin_o    (margin)
  );

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual oe/err/margin/data=%b/%b/%b/%h expected %b/%b/%b/%h",
               req, act[10], act[9], act[8], act[7:0], exp[10], exp[9], exp[8], exp[7:0]);
    end
  endtask

  // Drive on a falling edge, let two rising edges pass, sample on a falling edge.
  task automatic apply_and_check(input string req, input logic [15:0] a, input logic ce,
                                 input logic [1:0] l, input logic hv,
                                 input logic eoe, input logic eerr, input logic [7:0] ed);
    @(negedge clk);
    addr = a; ce_n = ce; lvl = l; id_hv = hv;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(req, {dout_oe, sig_err, margin, dout}, {eoe, eerr, margin, ed});
  endtask

  task automatic read_check(input string req, input logic [15:0] a, input logic [7:0] ed);
    apply_and_check(req, a, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, ed);
  endtask

  task automatic pulse(input logic [15:0] a, input logic [7:0] d, input logic [1:0] l,
                       input logic hv);
    @(negedge clk);
    addr = a; din = d; lvl = l; id_hv = hv; ce_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    ce_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    lvl = 2'b00; id_hv = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset outputs", {dout_oe, sig_err, margin, dout}, 11'b0);
    read_check("R1 blank byte", 16'h0005, 8'hFF);
    read_check("R1 blank last byte", 16'(DEPTH - 1), 8'hFF);
  endtask

  task automatic t_program;
    pulse(16'h0005, 8'hA5, 2'b10, 1'b0);
    read_check("R5 first program", 16'h0005, 8'hA5);
    pulse(16'h0005, 8'h0F, 2'b10, 1'b0);
    read_check("R5 AND with old", 16'h0005, 8'h05);
    pulse(16'h0005, 8'hFF, 2'b10, 1'b0);
    read_check("R5 ones cannot be restored", 16'h0005, 8'h05);
    read_check("R2 upper bits alias", 16'h0105, 8'h05);
    read_check("R2 neighbour untouched", 16'h0004, 8'hFF);
  endtask

  task automatic t_disable;
    apply_and_check("R3 output disable", 16'h0005, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 8'h00);
    apply_and_check("R4 standby low", 16'h0005, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 8'h00);
    apply_and_check("R4 standby high", 16'h0005, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk); din = 8'h00;
    apply_and_check("R6 inhibit floats", 16'h0006, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 8'h00);
    repeat (3) @(posedge clk);
    read_check("R6 inhibit no write", 16'h0006, 8'hFF);
    // Supply removed while chip enable still low: no commit.
    @(negedge clk);
    addr = 16'h0009; din = 8'h00; lvl = 2'b10; ce_n = 1'b0;
    repeat (2) @(posedge clk);
    read_check("R6 level dropped shows read", 16'h0009, 8'hFF);
    @(negedge clk); ce_n = 1'b1;
    repeat (3) @(posedge clk);
    read_check("R6 level dropped no commit", 16'h0009, 8'hFF);
  endtask

  task automatic t_signature;
    apply_and_check("R7 maker byte", 16'h0000, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 8'h20);
    apply_and_check("R7 device byte", 16'h0001, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 8'h3D);
    apply_and_check("R7 bit9 allowed", 16'h0201, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 8'h3D);
    apply_and_check("R8 stray bits", 16'h0005, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 8'h05);
  endtask

  task automatic t_margin;
    pulse(16'h0400, 8'h00, 2'b10, 1'b1);
    check("R10 margin set", {1'b0, 1'b0, margin, 8'h00}, {1'b0, 1'b0, 1'b1, 8'h00});
    read_check("R10 array untouched", 16'h0000, 8'hFF);
    pulse(16'h0000, 8'h00, 2'b10, 1'b1);
    check("R10 margin cleared", {1'b0, 1'b0, margin, 8'h00}, 11'b0);
  endtask

  task automatic t_reserved;
    apply_and_check("R11 code 11 disables", 16'h0005, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'h00);
    pulse(16'h0007, 8'h00, 2'b11, 1'b0);
    read_check("R11 code 11 no program", 16'h0007, 8'hFF);
  endtask

  task automatic t_erase;
    @(negedge clk); erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    read_check("R9 blank during sweep", 16'h0005, 8'hFF);
    pulse(16'h0008, 8'h00, 2'b10, 1'b0);
    repeat (DEPTH + 8) @(posedge clk);
    read_check("R9 program in sweep lost", 16'h0008, 8'hFF);
    read_check("R9 old byte erased", 16'h0005, 8'hFF);
    pulse(16'h0008, 8'h3C, 2'b10, 1'b0);
    read_check("R9 program after sweep", 16'h0008, 8'h3C);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    repeat (DEPTH + 8) @(posedge clk);
    t_program();
    t_disable();
    t_signature();
    t_margin();
    t_reserved();
    t_erase();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

endmodule